// File: doc/BRIEF.md
# Saturating Add/Subtract Unit with Sticky Overflow Flag

This block adds or subtracts two integer operands and, when the true result would not fit, returns the nearest representable limit instead of a wrapped value. Operands can be treated as signed or unsigned. The word can be processed as one full-width value or split into independent 16-bit or 8-bit lanes. Each lane clamps on its own. No carry crosses from one lane into the next.

Any clamp in any lane sets a single status flag. The flag stays set through later operations that do not clamp, so a long run of arithmetic can be checked for overflow once, at its end. The flag never interrupts the flow of operations. Only an explicit clear strobe returns it to zero.

Results appear one clock after a valid input and carry a matching valid output. The flag changes on the same edge as the result it reports.

Top module: `sat_addsub_unit`

## Requirements
- R1: Unsigned addition whose true sum exceeds the lane maximum returns all ones in that lane.
- R2: Unsigned subtraction with subtrahend greater than minuend returns zero in that lane.
- R3: Signed add or subtract beyond the lane range returns the most positive value (0 followed by ones) on positive overflow, and the most negative value (1 followed by zeros) on negative overflow.
- R4: When no clamping is needed, the lane result equals the exact sum or difference.
- R5: `lane_mode` encoding: 0 and 3 mean one full-width lane, 1 means 16-bit lanes, 2 means 8-bit lanes. Lane i occupies bits [i*w +: w]. Lanes saturate independently, with no carry or borrow between them.
- R6: The flag is high in the same cycle as a result in which any lane clamped.
- R7: An operation that does not clamp leaves the flag unchanged.
- R8: `flag_clr` clears the flag on the next edge. If a clamping operation is accepted in the same cycle, the flag ends set.
- R9: `out_valid` is high exactly one cycle after `in_valid`. `result` holds its value in cycles with no valid input.
- R10: After reset, `out_valid`, `sat_flag` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | DATA_W | First operand (minuend for subtract) |
| op_b | input | DATA_W | Second operand (subtrahend for subtract) |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| op_signed | input | 1 | 1 = two's complement operands, 0 = unsigned |
| lane_mode | input | 2 | Lane split, encoded as in R5 |
| flag_clr | input | 1 | Clear strobe for the sticky flag |
| out_valid | output | 1 | Result valid |
| result | output | DATA_W | Clamped result, registered |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The assertions check on every cycle that the flag falls only after a clear, rises only after an accepted clamping operation, and wins over a simultaneous clear. They also check that the output valid tracks the input valid with one cycle of delay, and that the result stays still between valid inputs. Only the bench scenarios can show that the clamped values are the correct limits in each signedness and lane split. The same holds for lane independence, where a clamp in one lane must leave its neighbours exact. These values come from a per-lane integer model in the bench.

// File: rtl/satu_pkg.sv
package satu_pkg;

    typedef enum logic [1:0] {
        LM_WORD     = 2'd0,
        LM_HALF     = 2'd1,
        LM_BYTE     = 2'd2,
        LM_WORD_ALT = 2'd3
    } lane_mode_e;

    typedef struct packed {
        logic sub;
        logic sgn;
    } op_ctl_t;

    // Number of lanes of width lw in a word of width dw.
    function automatic int lane_count(input int dw, input int lw);
        return dw / lw;
    endfunction

    // Lane width for a given mode, in bits.
    function automatic int mode_width(input lane_mode_e m, input int dw);
        case (m)
            LM_HALF: return 16;
            LM_BYTE: return 8;
            default: return dw;
        endcase
    endfunction

endpackage

// File: rtl/sat_lane.sv
module sat_lane
    import satu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  op_ctl_t      ctl,
    output logic [W-1:0] res,
    output logic         sat
);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] b_eff;
    logic [W:0]   sum_ext;
    logic [W-1:0] wrapped;
    logic         carry;
    logic         s_ovf;
    logic         u_ovf;

    always_comb begin
        b_eff   = ctl.sub ? ~b : b;
        sum_ext = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, ctl.sub};
        wrapped = sum_ext[W-1:0];
        carry   = sum_ext[W];
        // Signed: operands of equal sign whose sum flips sign.
        s_ovf   = (a[W-1] == b_eff[W-1]) && (wrapped[W-1] != a[W-1]);
        // Unsigned: carry out on add, missing carry (borrow) on subtract.
        u_ovf   = ctl.sub ? ~carry : carry;
        sat     = ctl.sgn ? s_ovf : u_ovf;
        if (!sat)
            res = wrapped;
        else if (ctl.sgn)
            res = a[W-1] ? SMIN : SMAX;
        else
            res = ctl.sub ? '0 : '1;
    end

endmodule

// File: rtl/sat_lane_array.sv
module sat_lane_array
    import satu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  op_ctl_t           ctl,
    output logic [DATA_W-1:0] res,
    output logic              sat_any
);
    localparam int NL = lane_count(DATA_W, LANE_W);

    logic [NL-1:0] sat_vec;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        sat_lane #(.W(LANE_W)) u_lane (
            .a   (a[i*LANE_W +: LANE_W]),
            .b   (b[i*LANE_W +: LANE_W]),
            .ctl (ctl),
            .res (res[i*LANE_W +: LANE_W]),
            .sat (sat_vec[i])
        );
    end

    assign sat_any = |sat_vec;

endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic set_ev,
    output logic flag
);
    logic run_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag     <= 1'b0;
            run_seen <= 1'b0;
        end else begin
            run_seen <= 1'b1;
            if (set_ev)
                flag <= 1'b1;
            else if (clr)
                flag <= 1'b0;
        end
    end

    // R7
    flag_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (run_seen && $fell(flag)) |-> $past(clr));

    // R6
    flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (run_seen && $rose(flag)) |-> $past(set_ev));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (run_seen && $past(set_ev)) |-> flag);

endmodule

// File: rtl/sat_addsub_unit.sv
module sat_addsub_unit
    import satu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              op_sub,
    input  logic              op_signed,
    input  logic [1:0]        lane_mode,
    input  logic              flag_clr,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              sat_flag
);
    localparam int HALF_W = 16;
    localparam int BYTE_W = 8;

    op_ctl_t           ctl;
    lane_mode_e        mode;
    logic [DATA_W-1:0] res_word, res_half, res_byte, res_sel;
    logic              sat_word, sat_half, sat_byte, sat_sel;
    logic              run_seen;

    assign ctl.sub = op_sub;
    assign ctl.sgn = op_signed;
    assign mode    = lane_mode_e'(lane_mode);

    sat_lane_array #(.DATA_W(DATA_W), .LANE_W(DATA_W)) u_word (
        .a(op_a), .b(op_b), .ctl(ctl), .res(res_word), .sat_any(sat_word));

    sat_lane_array #(.DATA_W(DATA_W), .LANE_W(HALF_W)) u_half (
        .a(op_a), .b(op_b), .ctl(ctl), .res(res_half), .sat_any(sat_half));

    sat_lane_array #(.DATA_W(DATA_W), .LANE_W(BYTE_W)) u_byte (
        .a(op_a), .b(op_b), .ctl(ctl), .res(res_byte), .sat_any(sat_byte));

    always_comb begin
        case (mode)
            LM_HALF: begin res_sel = res_half; sat_sel = sat_half; end
            LM_BYTE: begin res_sel = res_byte; sat_sel = sat_byte; end
            default: begin res_sel = res_word; sat_sel = sat_word; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            run_seen  <= 1'b0;
        end else begin
            run_seen  <= 1'b1;
            out_valid <= in_valid;
            if (in_valid)
                result <= res_sel;
        end
    end

    sticky_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .clr    (flag_clr),
        .set_ev (in_valid && sat_sel),
        .flag   (sat_flag)
    );

    // R9
    valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        run_seen |-> (out_valid == $past(in_valid)));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run_seen && !$past(in_valid)) |-> $stable(result));

endmodule

// File: tb/sim_sat_addsub_unit.sv
`timescale 1ns/1ps
module sim_sat_addsub_unit;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [DW-1:0] op_a, op_b;
    logic          op_sub, op_signed;
    logic [1:0]    lane_mode;
    logic          flag_clr;
    logic          out_valid;
    logic [DW-1:0] result;
    logic          sat_flag;

    int n_checks = 0;
    int n_errors = 0;
    logic exp_flag = 1'b0;
    logic [DW-1:0] last_res = '0;

    always #2 clk = ~clk;

    sat_addsub_unit #(.DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .op_sub(op_sub), .op_signed(op_signed), .lane_mode(lane_mode),
        .flag_clr(flag_clr), .out_valid(out_valid), .result(result),
        .sat_flag(sat_flag));

    initial begin
        #(4 * 190000);
        n_checks++; n_errors++;
        $display("FAIL watchdog: run did not complete (actual=timeout expected=done)");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Independent model: bit 32 is the saturation indication, bits 31:0 the result.
    function automatic logic [DW:0] model(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                          input logic sub, input logic sgn, input logic [1:0] md);
        int w;
        int n;
        longint mask, x, y, r, lo, hi;
        logic [DW-1:0] res;
        logic any;
        w = (md == 2'd1) ? 16 : (md == 2'd2) ? 8 : DW;
        n = DW / w;
        mask = (longint'(1) << w) - 1;
        res = '0;
        any = 1'b0;
        for (int i = 0; i < n; i++) begin
            x = (longint'(a) >> (i * w)) & mask;
            y = (longint'(b) >> (i * w)) & mask;
            if (sgn) begin
                if (x[w-1]) x = x - (longint'(1) << w);
                if (y[w-1]) y = y - (longint'(1) << w);
                lo = -(longint'(1) << (w - 1));
                hi = (longint'(1) << (w - 1)) - 1;
            end else begin
                lo = 0;
                hi = mask;
            end
            r = sub ? x - y : x + y;
            if (r > hi) begin r = hi; any = 1'b1; end
            if (r < lo) begin r = lo; any = 1'b1; end
            res = res | (DW'((r & mask) << (i * w)));
        end
        return {any, res};
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one operation at a negedge, then check at the following negedge.
    task automatic run_op(input string req, input logic [DW-1:0] a, input logic [DW-1:0] b,
                          input logic sub, input logic sgn, input logic [1:0] md, input logic clr);
        logic [DW:0] m;
        m = model(a, b, sub, sgn, md);
        op_a = a; op_b = b; op_sub = sub; op_signed = sgn; lane_mode = md;
        in_valid = 1'b1; flag_clr = clr;
        if (m[DW]) exp_flag = 1'b1;
        else if (clr) exp_flag = 1'b0;
        @(negedge clk);
        in_valid = 1'b0; flag_clr = 1'b0;
        last_res = m[DW-1:0];
        check({req, " result"}, result, m[DW-1:0]);
        check({req, " flag"}, DW'(sat_flag), DW'(exp_flag));
        check("R9 out_valid", DW'(out_valid), 32'd1);
    endtask

    task automatic idle_clear(input logic clr);
        in_valid = 1'b0; flag_clr = clr;
        if (clr) exp_flag = 1'b0;
        @(negedge clk);
        flag_clr = 1'b0;
        check("R8 flag after idle", DW'(sat_flag), DW'(exp_flag));
        check("R9 result hold", result, last_res);
        check("R9 out_valid low", DW'(out_valid), 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 1'b0; flag_clr = 1'b0;
        op_a = '0; op_b = '0; op_sub = 1'b0; op_signed = 1'b0; lane_mode = 2'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10 out_valid", DW'(out_valid), 32'd0);
        check("R10 sat_flag", DW'(sat_flag), 32'd0);
        check("R10 result", result, 32'd0);

        // R4 exact, no clamp
        run_op("R4", 32'd1000, 32'd234, 1'b0, 1'b0, 2'd0, 1'b0);
        run_op("R4", 32'd5, 32'd9, 1'b1, 1'b1, 2'd0, 1'b0);
        // R1 unsigned add clamp
        run_op("R1", 32'hFFFF_FFF0, 32'h20, 1'b0, 1'b0, 2'd0, 1'b0);
        // R7 flag held through non-clamping op
        run_op("R7", 32'd3, 32'd4, 1'b0, 1'b0, 2'd0, 1'b0);
        idle_clear(1'b0);
        // R8 plain clear
        idle_clear(1'b1);
        // R2 unsigned subtract clamps to zero
        run_op("R2", 32'd7, 32'd8, 1'b1, 1'b0, 2'd0, 1'b0);
        // R8 clear and clamp together: flag ends set
        run_op("R8", 32'h7FFF_FFFF, 32'd1, 1'b0, 1'b1, 2'd0, 1'b1);
        // R8 clear with non-clamping op: flag ends clear
        run_op("R8", 32'd1, 32'd1, 1'b0, 1'b1, 2'd0, 1'b1);
        // R3 signed positive and negative limits, subtract of most negative
        run_op("R3", 32'h8000_0000, 32'd1, 1'b1, 1'b1, 2'd0, 1'b0);
        run_op("R3", 32'd0, 32'h8000_0000, 1'b1, 1'b1, 2'd0, 1'b1);
        // R5 16-bit lanes: low lane clamps, high lane exact (no carry across)
        run_op("R5", 32'h0001_FFFF, 32'h0001_0001, 1'b0, 1'b0, 2'd1, 1'b1);
        // R5 8-bit signed lanes mixed
        run_op("R5", 32'h7F80_0110, 32'h0101_0F01, 1'b0, 1'b1, 2'd2, 1'b1);
        run_op("R5", 32'h0000_0000, 32'h0100_0001, 1'b1, 1'b0, 2'd2, 1'b1);
        // R5 mode 3 behaves as full width
        run_op("R5", 32'h0000_FFFF, 32'h0000_0001, 1'b0, 1'b0, 2'd3, 1'b1);
        // R6 clamp in a single byte lane raises flag with the result
        run_op("R6", 32'h0000_00FF, 32'h0000_0001, 1'b0, 1'b0, 2'd2, 1'b0);
        idle_clear(1'b1);

        // Random mix
        for (int k = 0; k < 400; k++) begin
            logic [DW-1:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            if (($urandom % 4) == 0) rb = rb >> ($urandom % 24);
            run_op("R4/R1/R2/R3/R5 random", ra, rb, 1'($urandom), 1'($urandom),
                   2'($urandom), (($urandom % 5) == 0));
            if (($urandom % 6) == 0) idle_clear(1'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule